// File: doc/BRIEF.md
# Two-Stage Sinc Decimator (Fourth-Order ×32 Followed by Programmable Averager)

This block turns a one-bit delta-sigma bit stream into signed 24-bit samples. A fourth-order sinc (CIC) section first reduces the rate by a fixed factor of 32. A first-order sinc section then adds up B consecutive results of the first section and dumps the sum. B is picked from a short menu. The output rate is therefore the modulator sample rate divided by 32·B. Putting the variable part of the decimation in a boxcar, rather than in a fourth-order section running at the full ratio, keeps the group delay short for a given output rate. The response still has exact nulls at every multiple of the output rate.

A modulator sample is taken on each clock in which `mod_en` is high. In normal use this is every second clock. A synchronous `restart`, or any change of `ratio_sel`, throws away all filter history. The data-ready strobe then stays quiet until the first output built only from fresh samples is ready. Each result is scaled so that full scale reads the same for every B.

Top module: `sinc41_decim`

## Requirements
- R1: A modulator sample is accepted only on a clock edge where `mod_en` is high; `mod_bit`=1 counts as +1 and 0 as −1; on edges with `mod_en` low, `mod_bit` has no effect.
- R2: The first stage is a fourth-order sinc over 32 accepted samples; it yields one value per 32 accepted samples, with DC gain 2^20, so its output lies within ±2^20.
- R3: The second stage sums B first-stage values and emits one result per B of them. `drdy` pulses once every 32·B accepted samples (64·B clocks when a sample arrives every second clock).
- R4: `ratio_sel` codes 0 to 8 select B = 2, 4, 10, 20, 40, 100, 200, 400, 1000 respectively; codes 9 to 15 select B = 2.
- R5: The result is sat24(floor(S·G / 2^16)), where S is the window sum and G = (floor(2^20/B)+1)>>1. For an input repeating every 8 samples with p ones per period, S = B·(2p−8)·2^17.
- R6: The result saturates to the range [−8388608, 8388607]; an all-ones stream with B=2 reads 8388607, and an all-zeros stream with B=2 reads −8388608.
- R7: After reset, restart or a ratio change, the first `drdy` belongs to the window that ends with accepted sample 32·(3+B). `drdy` rises two clock edges after the edge that accepted that sample.
- R8: `restart` high at a clock edge clears all filter state and discards any sample presented at that edge. No `drdy` appears until the settling of R7 has completed again.
- R9: A change of `ratio_sel` between two clock edges has the same effect as `restart`.
- R10: `drdy` is high for exactly one clock. `result` changes only on the clock where `drdy` rises and holds its value across `restart`.
- R11: While `rst_n` is low, `result` is 0 and `drdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Modulator sample qualifier |
| mod_bit | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| ratio_sel | input | 4 | Second-stage ratio code |
| restart | input | 1 | Synchronous filter restart |
| result | output | 24 | Signed output sample |
| drdy | output | 1 | One-clock data-ready strobe |

## Verification
The stimuli are streams that repeat every 8 samples. Because 8 divides 32, the first-stage output of such a stream is an exact constant, so every expected sum follows in closed form for each menu entry. Settling is checked to the exact sample and clock. A design that counts the three warm-up decimations wrongly, or that keeps a sample presented together with `restart`, produces its first strobe early or late. A design that does not clear on a ratio change produces a strobe early from stale history. A design that samples `mod_bit` while `mod_en` is low either gets the timing wrong or reads the wrong level for a stream paused in the middle of a window. The two full-scale cases with B=2 show whether the multiply and saturation are right: a missing clamp wraps the positive extreme to a negative value.

// File: rtl/sinc41_pkg.sv
package sinc41_pkg;

    // Number of selectable second-stage ratios and width of the ratio counter.
    localparam int unsigned NUM_RATIOS = 9;
    localparam int unsigned RATIO_W    = 10;

    // Ratio menu; codes beyond the menu fall back to the smallest ratio.
    function automatic int unsigned ratio_of(input int unsigned code);
        case (code)
            0:       return 2;
            1:       return 4;
            2:       return 10;
            3:       return 20;
            4:       return 40;
            5:       return 100;
            6:       return 200;
            7:       return 400;
            8:       return 1000;
            default: return 2;
        endcase
    endfunction

    // Rounded scale factor so that (sum * gain) >>> gshift spans the output range
    // independently of the ratio: gain = round(2^(gshift+out_w-1) / (b * 2^stage1_bits)).
    function automatic longint unsigned gain_of(input int unsigned b,
                                                input int unsigned stage1_bits,
                                                input int unsigned out_w,
                                                input int unsigned gshift);
        longint unsigned num;
        longint unsigned quo;
        num = 64'd1 << (gshift + out_w - stage1_bits);
        quo = num / longint'(b);
        return (quo + 64'd1) >> 1;
    endfunction

    // First-stage restart/decimation bookkeeping of the top level.
    typedef struct packed {
        logic [3:0] sel;
        logic [7:0] phase;
        logic       dec;
    } top_state_t;

endpackage

// File: rtl/sinc41_integ.sv
// Cascade of integrators running at the modulator sample rate.
// Each stage adds the previous stage's registered value (one adder per stage).
module sinc41_integ #(
    parameter int ORDER = 4,
    parameter int W     = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         sgn,
    output logic [W-1:0] acc_out
);

    typedef struct packed {
        logic [ORDER-1:0][W-1:0] stg;
    } integ_t;

    integ_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.stg[0] = st_q.stg[0] + (sgn ? W'(1) : {W{1'b1}});
            for (int k = 1; k < ORDER; k++) begin
                st_d.stg[k] = st_q.stg[k] + st_q.stg[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out = st_q.stg[ORDER-1];

endmodule

// File: rtl/sinc41_comb.sv
// Comb cascade at the decimated rate, differential delay of one.
// Flags its output valid only once ORDER decimation events have passed since a clear.
module sinc41_comb #(
    parameter int ORDER = 4,
    parameter int W     = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         go,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         vld
);

    localparam int WARM_W = $clog2(ORDER + 1);

    typedef struct packed {
        logic [ORDER-1:0][W-1:0] dly;
        logic [W-1:0]            y;
        logic                    vld;
        logic [WARM_W-1:0]       warm;
    } comb_t;

    comb_t cs_d, cs_q;
    logic [W-1:0] v_run;
    logic [W-1:0] v_dif;

    always_comb begin
        cs_d     = cs_q;
        cs_d.vld = 1'b0;
        v_run    = '0;
        v_dif    = '0;
        if (clr) begin
            cs_d = '0;
        end else if (go) begin
            v_run = din;
            for (int k = 0; k < ORDER; k++) begin
                v_dif       = v_run - cs_q.dly[k];
                cs_d.dly[k] = v_run;
                v_run       = v_dif;
            end
            cs_d.y   = v_run;
            cs_d.vld = (cs_q.warm == WARM_W'(ORDER - 1));
            if (cs_q.warm != WARM_W'(ORDER - 1)) begin
                cs_d.warm = cs_q.warm + WARM_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign dout = cs_q.y;
    assign vld  = cs_q.vld;

endmodule

// File: rtl/sinc41_avg.sv
// First-order sinc: accumulate-and-dump over a programmable window,
// then multiply-and-shift scaling with saturation to the output width.
module sinc41_avg #(
    parameter int IN_W    = 22,
    parameter int ACC_W   = 32,
    parameter int GAIN_W  = 20,
    parameter int OUT_W   = 24,
    parameter int GSHIFT  = 16,
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               in_vld,
    input  logic [IN_W-1:0]    din,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [GAIN_W-1:0]  gain,
    output logic [OUT_W-1:0]   result,
    output logic               drdy
);

    localparam int PROD_W = ACC_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] SAT_HI =
        {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SAT_LO =
        {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [RATIO_W-1:0] cnt;
        logic [OUT_W-1:0]   res;
        logic               rdy;
    } avg_t;

    avg_t as_d, as_q;

    logic signed [ACC_W-1:0]  total;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic [OUT_W-1:0]         clipped;

    always_comb begin
        total   = $signed(as_q.acc) + $signed({{(ACC_W-IN_W){din[IN_W-1]}}, din});
        prod    = $signed({{(PROD_W-ACC_W){total[ACC_W-1]}}, total})
                * $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
        shifted = prod >>> GSHIFT;
        if (shifted > SAT_HI)      clipped = SAT_HI[OUT_W-1:0];
        else if (shifted < SAT_LO) clipped = SAT_LO[OUT_W-1:0];
        else                       clipped = shifted[OUT_W-1:0];
    end

    always_comb begin
        as_d     = as_q;
        as_d.rdy = 1'b0;
        if (clr) begin
            as_d.acc = '0;
            as_d.cnt = '0;
        end else if (in_vld) begin
            if (as_q.cnt == ratio - RATIO_W'(1)) begin
                as_d.res = clipped;
                as_d.rdy = 1'b1;
                as_d.acc = '0;
                as_d.cnt = '0;
            end else begin
                as_d.acc = total;
                as_d.cnt = as_q.cnt + RATIO_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) as_q <= '0;
        else        as_q <= as_d;
    end

    assign result = as_q.res;
    assign drdy   = as_q.rdy;

endmodule

// File: rtl/sinc41_decim.sv
module sinc41_decim #(
    parameter int DEC1   = 32,
    parameter int ORDER  = 4,
    parameter int OUT_W  = 24,
    parameter int SEL_W  = 4,
    parameter int GSHIFT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             mod_bit,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             restart,
    output logic [OUT_W-1:0] result,
    output logic             drdy
);
    import sinc41_pkg::*;

    localparam int PHASE_W     = $clog2(DEC1);
    localparam int STAGE1_BITS = ORDER * PHASE_W;
    localparam int CIC_W       = STAGE1_BITS + 2;
    localparam int ACC_W       = CIC_W + RATIO_W;
    localparam int GAIN_W      = GSHIFT + OUT_W - STAGE1_BITS;

    // Ratio and gain look-up, built from the package functions at elaboration.
    logic [RATIO_W-1:0] ratio_lut [NUM_RATIOS];
    logic [GAIN_W-1:0]  gain_lut  [NUM_RATIOS];

    for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_lut
        assign ratio_lut[gi] = RATIO_W'(ratio_of(gi));
        assign gain_lut[gi]  = GAIN_W'(gain_of(ratio_of(gi), STAGE1_BITS, OUT_W, GSHIFT));
    end

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [PHASE_W-1:0] phase;
        logic               dec;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic               clr;
    logic [SEL_W-1:0]   sel_eff;
    logic [RATIO_W-1:0] ratio_cur;
    logic [GAIN_W-1:0]  gain_cur;
    logic [CIC_W-1:0]   integ_out;
    logic [CIC_W-1:0]   s4_val;
    logic               s4_vld;
    logic               take;

    assign clr       = restart | (ratio_sel != ct_q.sel);
    assign take      = mod_en & ~clr;
    assign sel_eff   = (ratio_sel < SEL_W'(NUM_RATIOS)) ? ratio_sel : '0;
    assign ratio_cur = ratio_lut[sel_eff];
    assign gain_cur  = gain_lut[sel_eff];

    always_comb begin
        ct_d     = ct_q;
        ct_d.sel = ratio_sel;
        ct_d.dec = 1'b0;
        if (clr) begin
            ct_d.phase = '0;
        end else if (mod_en) begin
            ct_d.dec = (ct_q.phase == PHASE_W'(DEC1 - 1));
            if (ct_q.phase == PHASE_W'(DEC1 - 1)) ct_d.phase = '0;
            else                                  ct_d.phase = ct_q.phase + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    sinc41_integ #(
        .ORDER (ORDER),
        .W     (CIC_W)
    ) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (take),
        .sgn     (mod_bit),
        .acc_out (integ_out)
    );

    sinc41_comb #(
        .ORDER (ORDER),
        .W     (CIC_W)
    ) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .go    (ct_q.dec),
        .din   (integ_out),
        .dout  (s4_val),
        .vld   (s4_vld)
    );

    sinc41_avg #(
        .IN_W    (CIC_W),
        .ACC_W   (ACC_W),
        .GAIN_W  (GAIN_W),
        .OUT_W   (OUT_W),
        .GSHIFT  (GSHIFT),
        .RATIO_W (RATIO_W)
    ) u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .in_vld (s4_vld),
        .din    (s4_val),
        .ratio  (ratio_cur),
        .gain   (gain_cur),
        .result (result),
        .drdy   (drdy)
    );

endmodule

// File: rtl/sinc41_chk.sv
module sinc41_chk #(
    parameter int DEC1  = 32,
    parameter int ORDER = 4,
    parameter int OUT_W = 24,
    parameter int SEL_W = 4,
    parameter int CIC_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             restart,
    input logic [OUT_W-1:0] result,
    input logic             drdy,
    input logic             clr,
    input logic             s4_vld,
    input logic [CIC_W-1:0] s4_val
);
    import sinc41_pkg::*;

    localparam int STAGE1_BITS = ORDER * $clog2(DEC1);
    localparam logic signed [CIC_W-1:0] FS_POS = CIC_W'(1) << STAGE1_BITS;
    localparam logic signed [CIC_W-1:0] FS_NEG = -FS_POS;

    // Samples accepted since the last clear, saturating.
    logic [31:0] seen_q;
    logic [31:0] need;

    always_ff @(posedge clk) begin
        if (!rst_n)                               seen_q <= '0;
        else if (clr)                             seen_q <= '0;
        else if (mod_en && seen_q != 32'hFFFF_FFFF) seen_q <= seen_q + 32'd1;
    end

    assign need = 32'(DEC1 * (ORDER - 1)) + 32'(DEC1) * 32'(ratio_of(int'(ratio_sel)));

    // R10: strobe lasts one clock
    a_r10_drdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |=> !drdy);

    // R10: output word only moves with the strobe
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy |-> $stable(result));

    // R2: first-stage values stay within its full scale
    a_r2_s4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s4_vld |-> ($signed(s4_val) <= FS_POS && $signed(s4_val) >= FS_NEG));

    // R8: restart silences the pipeline on the next clock
    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!drdy && !s4_vld));

    // R9: a ratio change silences the strobe on the next clock
    a_r9_ratio_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel != $past(ratio_sel)) |=> !drdy);

    // R7: no strobe before enough fresh samples have been accepted
    a_r7_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy && !clr) |-> (seen_q >= need));

endmodule

bind sinc41_decim sinc41_chk #(
    .DEC1  (DEC1),
    .ORDER (ORDER),
    .OUT_W (OUT_W),
    .SEL_W (SEL_W),
    .CIC_W (CIC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .ratio_sel (ratio_sel),
    .restart   (restart),
    .result    (result),
    .drdy      (drdy),
    .clr       (clr),
    .s4_vld    (s4_vld),
    .s4_val    (s4_val)
);

// File: tb/sinc41_decim_tb_top.sv
`timescale 1ns/1ps
module sinc41_decim_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic [3:0]  ratio_sel = 4'd0;
    logic        restart = 1'b0;
    logic [23:0] result;
    logic        drdy;

    always #2.5 clk = ~clk;

    sinc41_decim dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_en    (mod_en),
        .mod_bit   (mod_bit),
        .ratio_sel (ratio_sel),
        .restart   (restart),
        .result    (result),
        .drdy      (drdy)
    );

    typedef struct packed {
        logic [3:0] sel;
        logic [7:0] pat;
        logic [3:0] nout;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 8'hFF, 4'd3},
        '{4'd0, 8'h00, 4'd2},
        '{4'd1, 8'hAA, 4'd2},
        '{4'd2, 8'hEE, 4'd2},
        '{4'd3, 8'h11, 4'd2},
        '{4'd4, 8'h7F, 4'd2},
        '{4'd5, 8'h01, 4'd1},
        '{4'd6, 8'hFE, 4'd1},
        '{4'd7, 8'h1F, 4'd1},
        '{4'd8, 8'hC0, 4'd1}
    };

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int          n_rdy = 0;
    int          rdy_cyc [16];
    logic [23:0] rdy_val [16];
    int          acc_cnt = 0;
    int          cap_target = 0;
    int          cap_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && drdy) begin
            if (n_rdy < 16) begin
                rdy_cyc[n_rdy] = cyc;
                rdy_val[n_rdy] = result;
            end
            n_rdy = n_rdy + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc >= 190000 && !finished) begin
            finished = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_b(input int code);
        case (code)
            0: return 2;   1: return 4;   2: return 10;
            3: return 20;  4: return 40;  5: return 100;
            6: return 200; 7: return 400; 8: return 1000;
            default: return 2;
        endcase
    endfunction

    function automatic longint exp_res(input int b, input int pc);
        longint s;
        longint g;
        longint v;
        s = longint'(b) * longint'(2 * pc - 8) * 64'sd131072;
        g = ((64'sd1048576 / longint'(b)) + 1) / 2;
        v = (s * g) >>> 16;
        if (v > 64'sd8388607)  v = 64'sd8388607;
        if (v < -64'sd8388608) v = -64'sd8388608;
        return v;
    endfunction

    task automatic send(input logic [7:0] pat, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mod_en  = 1'b1;
            mod_bit = pat[acc_cnt & 7];
            acc_cnt = acc_cnt + 1;
            if (acc_cnt == cap_target) cap_cyc = cyc + 1;
            @(negedge clk);
            mod_en = 1'b0;
        end
    endtask

    task automatic do_restart(input logic with_sample);
        @(negedge clk);
        restart = 1'b1;
        mod_en  = with_sample;
        mod_bit = 1'b0;
        @(negedge clk);
        restart = 1'b0;
        mod_en  = 1'b0;
        acc_cnt = 0;
    endtask

    task automatic settle_out();
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input int sel, input logic [7:0] pat, input int nout, input string tag);
        int b;
        b = ratio_b(sel);
        @(negedge clk);
        ratio_sel = 4'(sel);
        do_restart(1'b0);
        n_rdy = 0;
        cap_target = 32 * (3 + b);
        send(pat, 32 * (3 + b) + 32 * b * (nout - 1));
        settle_out();
        check({tag, " R3 output count"}, n_rdy, nout);
        if (n_rdy >= 1) check({tag, " R7 first strobe latency"}, rdy_cyc[0] - cap_cyc, 2);
        for (int j = 0; j < nout && j < n_rdy && j < 16; j++) begin
            check({tag, " R5 R4 value"}, longint'($signed(rdy_val[j])), exp_res(b, $countones(pat)));
            if (j > 0) check({tag, " R3 strobe spacing"}, rdy_cyc[j] - rdy_cyc[j-1], 64 * b);
        end
    endtask

    initial begin
        // R11: reset state
        repeat (5) @(negedge clk);
        check("R11 result in reset", longint'(result), 0);
        check("R11 drdy in reset", longint'(drdy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 result after reset", longint'(result), 0);

        // Vector table: every ratio code with a range of stream densities
        for (int v = 0; v < NVEC; v++) begin
            run_case(int'(VECS[v].sel), VECS[v].pat, int'(VECS[v].nout), $sformatf("vec%0d", v));
        end

        // R6: extremes at the smallest ratio
        run_case(0, 8'hFF, 1, "R6 positive clamp");
        check("R6 positive clamp", longint'($signed(rdy_val[0])), 8388607);
        run_case(0, 8'h00, 1, "R6 negative extreme");
        check("R6 negative extreme", longint'($signed(rdy_val[0])), -8388608);

        // R4: code beyond the menu behaves as B=2
        run_case(12, 8'h3F, 2, "R4 out-of-menu code");

        // R8 / R10: restart mid-window with a sample at the restart edge
        run_case(0, 8'hFF, 1, "R8 prefill");
        send(8'hFF, 40);
        do_restart(1'b1);
        check("R10 result held across restart", longint'($signed(result)), 8388607);
        n_rdy = 0;
        cap_target = 160;
        send(8'h00, 160);
        settle_out();
        check("R8 count after restart", n_rdy, 1);
        if (n_rdy >= 1) begin
            check("R8 latency after restart", rdy_cyc[0] - cap_cyc, 2);
            check("R8 value after restart", longint'($signed(rdy_val[0])), -8388608);
        end

        // R9: ratio change without restart discards history
        @(negedge clk);
        ratio_sel = 4'd1;
        do_restart(1'b0);
        n_rdy = 0;
        cap_target = 0;
        send(8'hFF, 100);
        check("R9 no output before switch", n_rdy, 0);
        @(negedge clk);
        ratio_sel = 4'd0;
        acc_cnt = 0;
        n_rdy = 0;
        cap_target = 160;
        send(8'h3F, 160);
        settle_out();
        check("R9 count after ratio change", n_rdy, 1);
        if (n_rdy >= 1) begin
            check("R9 latency after ratio change", rdy_cyc[0] - cap_cyc, 2);
            check("R9 value after ratio change", longint'($signed(rdy_val[0])), exp_res(2, 6));
        end

        // R1: toggling mod_bit with mod_en low inside a window changes nothing
        do_restart(1'b0);
        n_rdy = 0;
        cap_target = 160;
        send(8'h3F, 100);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            mod_en  = 1'b0;
            mod_bit = i[0];
        end
        check("R1 no strobe while idle", n_rdy, 0);
        send(8'h3F, 60);
        settle_out();
        check("R1 count with idle gap", n_rdy, 1);
        if (n_rdy >= 1) begin
            check("R1 latency with idle gap", rdy_cyc[0] - cap_cyc, 2);
            check("R1 value with idle gap", longint'($signed(rdy_val[0])), exp_res(2, 6));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule